// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Data Cache

This block sits between a processor's load/store port and a word-wide memory port. Each request address is cut into three fields. The low bits pick a byte and then a word within a 16-byte line. The middle bits pick a set. The top bits form the tag. For the chosen set, the tags, valid bits, dirty bits and data words of all four ways are read in the same cycle. Every tag is compared against the request at once, so a hit returns its word, or takes its write, with no wait cycle.

On a miss the controller picks a victim way in that set. An empty way is taken first. If every way holds a line, the least recently touched way is taken. If the victim holds modified data, the whole line is first written out to memory as four word beats. The new line is then read in as four word beats. The request is looked up again and now hits. Writes allocate on a miss and never go straight to memory. A write changes one 32-bit word of a line and marks that line dirty. The processor must hold its request steady until `cpu_ready` is high for one cycle.

Top module: `sa_wb_cache`

## Requirements
- R1: Request address bits [3:2] select the word within a line, bits [3+SET_W:4] select the set, and the remaining upper bits are the tag; lines that differ only in set never evict one another.
- R2: A request that hits asserts `cpu_ready` in the same cycle it is presented, with no memory beat; `cpu_ready` is never high without `cpu_valid`.
- R3: A read returns the most recently written value of the addressed word, whether that value came from memory or from an earlier cached write.
- R4: A miss reads the line as four beats at line base + 0, 4, 8, 12 in that order, then completes the request.
- R5: The victim is the lowest-numbered invalid way of the set if one exists, otherwise the least recently used way; every completed access makes its way the most recent.
- R6: A write hit changes only the cache and issues no memory write.
- R7: A dirty victim is written to memory as four beats at its own line base + 0, 4, 8, 12 before the fill starts; a clean victim causes no memory write.
- R8: A write miss fills the line and then applies the write to the cache only, leaving memory's copy of that word unchanged.
- R9: A memory beat transfers only when `mem_valid` and `mem_ready` are both high; while stalled, address, direction and write data stay constant.
- R10: After reset no memory request is pending and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Request present, held until accepted |
| cpu_we | input | 1 | 1 = write one word, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the word |
| cpu_wdata | input | WORD_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | WORD_W | Read data, valid with `cpu_ready` |
| mem_valid | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | ADDR_W | Word address of the beat |
| mem_wdata | output | WORD_W | Write-back data |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | WORD_W | Fill data, valid with `mem_ready` on reads |

## Verification
The bench fills one set with four tags and touches the oldest one again. It then forces an eviction and checks that the second-oldest line was dropped. A design that evicted by way number or by fill order would instead lose the line that was just reused. A dirty line is evicted and the bench checks the order and base address of the write-back beats. A design that built the write-back address from the new tag, or skipped the write-back, would leave stale words in memory. A clean eviction must cause no write at all. A sweep of mixed reads and writes runs against a memory that stalls now and then, followed by a full read-back of every word. This catches beats that advance without a handshake and writes that fail to set the dirty bit.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
// Shared types for the set-associative cache.
// Assumes nothing beyond the three controller phases listed below.
package cache_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,   // compare all ways, serve hits
        ST_WBACK  = 2'd1,   // stream dirty victim to memory
        ST_FILL   = 2'd2    // stream new line in from memory
    } cache_state_e;
endpackage

// File: rtl/cache_lru.sv
`timescale 1ns/1ps
// Per-set recency tracker and victim chooser.
// Each way of each set keeps an age; 0 is the youngest and WAYS-1 the oldest.
// The ages of one set always form a permutation. Assumes WAYS is a power of two.
module cache_lru #(
    parameter int SETS = 8,
    parameter int WAYS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(SETS)-1:0]  set_idx,
    input  logic [WAYS-1:0]          way_valid,
    input  logic                     touch_en,
    input  logic [$clog2(WAYS)-1:0]  touch_way,
    output logic [$clog2(WAYS)-1:0]  victim_way
);
    localparam int AGE_W = $clog2(WAYS);
    localparam int WAY_W = $clog2(WAYS);

    logic [AGE_W-1:0] age_q [SETS][WAYS];

    // Age update: touched way becomes youngest, younger ones age by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    age_q[s][w] <= AGE_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    age_q[set_idx][w] <= '0;
                else if (age_q[set_idx][w] < age_q[set_idx][touch_way])
                    age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
            end
        end
    end

    // Victim choice: first empty way, else the oldest way.
    always_comb begin
        logic found;
        found      = 1'b0;
        victim_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!way_valid[w] && !found) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++)
                if (age_q[set_idx][w] == AGE_W'(WAYS-1))
                    victim_way = WAY_W'(w);
        end
    end

    // Ages of the addressed set, collected for the permutation check.
    logic [WAYS-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int w = 0; w < WAYS; w++)
            age_seen[age_q[set_idx][w]] = 1'b1;
    end

    // R5
    age_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(age_seen) == WAYS);

    // R5
    touch_young_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> age_q[$past(set_idx)][$past(touch_way)] == '0);
endmodule

// File: rtl/cache_store.sv
`timescale 1ns/1ps
// Tag, state and data storage for all ways.
// One set index addresses every way at once; all ways are read in parallel.
// Fill beats write one word each; the last beat also installs tag and valid
// and clears dirty. A CPU write updates one word and sets dirty.
// Assumes fill and CPU writes never occur in the same cycle.
module cache_store #(
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int WPL    = 4,
    parameter int WORD_W = 32,
    parameter int TAG_W  = 25
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [$clog2(SETS)-1:0]              set_idx,
    input  logic                                 fill_en,
    input  logic                                 fill_last,
    input  logic [$clog2(WAYS)-1:0]              fill_way,
    input  logic [$clog2(WPL)-1:0]               fill_word,
    input  logic [WORD_W-1:0]                    fill_data,
    input  logic [TAG_W-1:0]                     fill_tag,
    input  logic                                 wr_en,
    input  logic [$clog2(WAYS)-1:0]              wr_way,
    input  logic [$clog2(WPL)-1:0]               wr_word,
    input  logic [WORD_W-1:0]                    wr_data,
    output logic [WAYS-1:0][TAG_W-1:0]           rd_tag,
    output logic [WAYS-1:0]                      rd_valid,
    output logic [WAYS-1:0]                      rd_dirty,
    output logic [WAYS-1:0][WPL-1:0][WORD_W-1:0] rd_data
);
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic              valid_q [SETS][WAYS];
    logic              dirty_q [SETS][WAYS];
    logic [WORD_W-1:0] data_q  [SETS][WAYS][WPL];

    // State bits: cleared by reset, set by fill completion or CPU write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    valid_q[s][w] <= 1'b0;
                    dirty_q[s][w] <= 1'b0;
                end
        end else if (fill_last) begin
            valid_q[set_idx][fill_way] <= 1'b1;
            dirty_q[set_idx][fill_way] <= 1'b0;
        end else if (wr_en) begin
            dirty_q[set_idx][wr_way] <= 1'b1;
        end
    end

    // Tag and data words: no reset needed, guarded by valid.
    always_ff @(posedge clk) begin
        if (fill_en)
            data_q[set_idx][fill_way][fill_word] <= fill_data;
        else if (wr_en)
            data_q[set_idx][wr_way][wr_word] <= wr_data;
        if (fill_last)
            tag_q[set_idx][fill_way] <= fill_tag;
    end

    // Parallel read of every way of the addressed set.
    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            rd_tag[w]   = tag_q[set_idx][w];
            rd_valid[w] = valid_q[set_idx][w];
            rd_dirty[w] = dirty_q[set_idx][w];
            for (int k = 0; k < WPL; k++)
                rd_data[w][k] = data_q[set_idx][w][k];
        end
    end

    // R6
    write_valid_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> valid_q[set_idx][wr_way]);

    // R4
    fill_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_last |=> valid_q[$past(set_idx)][$past(fill_way)] &&
                      !dirty_q[$past(set_idx)][$past(fill_way)]);
endmodule

// File: rtl/sa_wb_cache.sv
`timescale 1ns/1ps
// Four-way set-associative write-back, write-allocate data cache.
// Hits complete combinationally in the cycle they are presented. Misses
// write back a dirty victim, fill the line in WPL word beats, then re-look-up.
// Assumes the CPU holds cpu_valid/cpu_we/cpu_addr/cpu_wdata stable until
// cpu_ready, and that addresses are word aligned.
module sa_wb_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int SETS   = 8,
    parameter int WAYS   = 4,
    parameter int WPL    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ready,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int BYTE_W = $clog2(WORD_W/8);
    localparam int WIDX_W = $clog2(WPL);
    localparam int SET_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TAG_W  = ADDR_W - SET_W - WIDX_W - BYTE_W;

    // Address fields of the held request.
    logic [WIDX_W-1:0] req_word;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    assign req_word = cpu_addr[BYTE_W +: WIDX_W];
    assign req_set  = cpu_addr[BYTE_W+WIDX_W +: SET_W];
    assign req_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

    cache_state_e      state_q;
    logic [WIDX_W-1:0] beat_q;
    logic [WAY_W-1:0]  victim_q;

    logic [WAYS-1:0][TAG_W-1:0]           st_tag;
    logic [WAYS-1:0]                      st_valid;
    logic [WAYS-1:0]                      st_dirty;
    logic [WAYS-1:0][WPL-1:0][WORD_W-1:0] st_data;
    logic [WAY_W-1:0]                     lru_victim;

    logic [WAYS-1:0]  hit_vec;
    logic [WAY_W-1:0] hit_way;
    logic             hit;
    logic             beat_done;
    logic             last_beat;
    logic             fill_en;
    logic             fill_last;
    logic             wr_en;

    // Parallel tag compare, one comparator per way.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = st_valid[w] && (st_tag[w] == req_tag);
    end

    // Hit way encoder.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) hit_way = WAY_W'(w);
    end

    assign hit       = |hit_vec;
    assign cpu_ready = cpu_valid && (state_q == ST_LOOKUP) && hit;
    assign cpu_rdata = st_data[hit_way][req_word];
    assign beat_done = mem_valid && mem_ready;
    assign last_beat = (beat_q == WIDX_W'(WPL-1));
    assign fill_en   = (state_q == ST_FILL) && beat_done;
    assign fill_last = fill_en && last_beat;
    assign wr_en     = cpu_ready && cpu_we;

    // Miss sequencing: choose victim, write back if dirty, fill, re-look-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_LOOKUP;
            beat_q   <= '0;
            victim_q <= '0;
        end else begin
            case (state_q)
                ST_LOOKUP: begin
                    if (cpu_valid && !hit) begin
                        victim_q <= lru_victim;
                        beat_q   <= '0;
                        state_q  <= (st_valid[lru_victim] && st_dirty[lru_victim])
                                    ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: begin
                    if (beat_done) begin
                        beat_q <= last_beat ? '0 : beat_q + 1'b1;
                        if (last_beat) state_q <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (beat_done) begin
                        beat_q <= last_beat ? '0 : beat_q + 1'b1;
                        if (last_beat) state_q <= ST_LOOKUP;
                    end
                end
                default: state_q <= ST_LOOKUP;
            endcase
        end
    end

    // Memory beat request: victim line out, or requested line in.
    always_comb begin
        mem_valid = (state_q == ST_WBACK) || (state_q == ST_FILL);
        mem_we    = (state_q == ST_WBACK);
        mem_wdata = st_data[victim_q][beat_q];
        if (state_q == ST_WBACK)
            mem_addr = {st_tag[victim_q], req_set, beat_q, {BYTE_W{1'b0}}};
        else
            mem_addr = {req_tag, req_set, beat_q, {BYTE_W{1'b0}}};
    end

    cache_store #(
        .SETS(SETS), .WAYS(WAYS), .WPL(WPL), .WORD_W(WORD_W), .TAG_W(TAG_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_idx   (req_set),
        .fill_en   (fill_en),
        .fill_last (fill_last),
        .fill_way  (victim_q),
        .fill_word (beat_q),
        .fill_data (mem_rdata),
        .fill_tag  (req_tag),
        .wr_en     (wr_en),
        .wr_way    (hit_way),
        .wr_word   (req_word),
        .wr_data   (cpu_wdata),
        .rd_tag    (st_tag),
        .rd_valid  (st_valid),
        .rd_dirty  (st_dirty),
        .rd_data   (st_data)
    );

    cache_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_idx    (req_set),
        .way_valid  (st_valid),
        .touch_en   (cpu_ready),
        .touch_way  (hit_way),
        .victim_way (lru_victim)
    );

    // R2
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid && !mem_valid);

    // R2
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata));

    // R6
    write_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_we |=> !(mem_valid && mem_we && $past(hit)));

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_valid);
endmodule

// File: tb/sa_wb_cache_bench.sv
`timescale 1ns/1ps
// Bench: stalling word memory model, shadow reference memory, directed
// replacement and write-back cases, then a mixed sweep and full read-back.
module sa_wb_cache_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mem_valid;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready;
    logic [31:0] mem_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int rd_beats = 0;
    int wr_beats = 0;
    logic [31:0] rd_log [16];
    logic [31:0] wr_log [16];
    logic [31:0] mem_model [256];
    logic [31:0] ref_mem [256];
    logic [1:0]  stall_q = 2'd0;

    always #10 clk = ~clk;

    sa_wb_cache u_sa_wb_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
    );

    // Memory: stalls one cycle in four, reads combinational.
    assign mem_ready = (stall_q != 2'd1);
    assign mem_rdata = mem_model[mem_addr[9:2]];

    always @(posedge clk) begin
        stall_q <= stall_q + 2'd1;
        if (mem_valid && mem_ready) begin
            if (mem_we) begin
                mem_model[mem_addr[9:2]] <= mem_wdata;
                wr_log[wr_beats % 16] <= mem_addr;
                wr_beats <= wr_beats + 1;
            end else begin
                rd_log[rd_beats % 16] <= mem_addr;
                rd_beats <= rd_beats + 1;
            end
        end
    end

    function automatic logic [31:0] mk(int t, int s, int w);
        return 32'((t << 7) | (s << 4) | (w << 2));
    endfunction

    function automatic logic [31:0] init_val(int i);
        return 32'hA500_0000 ^ 32'(i * 32'h0001_0203);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One CPU access; cyc counts wait cycles before cpu_ready.
    task automatic access(input bit we, input logic [31:0] addr,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output int cyc);
        @(negedge clk);
        cpu_valid = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        cyc = 0; rd = '0;
        forever begin
            #1;
            if (cpu_ready) begin
                rd = cpu_rdata;
                break;
            end
            if (cyc > 500) begin
                chk(1'b0, "R4 access timeout", 32'(cyc), 32'd500);
                break;
            end
            @(negedge clk);
            cyc++;
        end
        @(posedge clk);
        #1;
        cpu_valid = 1'b0; cpu_we = 1'b0;
        if (we) ref_mem[addr[9:2]] = wd;
    endtask

    task automatic rd_chk(input logic [31:0] addr, input string req);
        logic [31:0] rd;
        int cyc;
        access(1'b0, addr, '0, rd, cyc);
        chk(rd == ref_mem[addr[9:2]], req, rd, ref_mem[addr[9:2]]);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int cyc, r0, w0;
        logic [15:0] lfsr;
        for (int i = 0; i < 256; i++) begin
            mem_model[i] = init_val(i);
            ref_mem[i]   = init_val(i);
        end
        repeat (3) @(posedge clk);
        #1;
        // R10: no memory request while in and just after reset.
        chk(!mem_valid, "R10 mem_valid in reset", 32'(mem_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_valid && !cpu_ready, "R10 idle after reset",
            {30'd0, mem_valid, cpu_ready}, 0);

        // R10, R4: first access misses; fill beats in line order.
        r0 = rd_beats; w0 = wr_beats;
        access(1'b0, mk(0, 0, 2), '0, rd, cyc);
        chk(rd == ref_mem[mk(0,0,2) >> 2], "R3 first read data", rd, ref_mem[mk(0,0,2) >> 2]);
        chk(rd_beats - r0 == 4, "R10 R4 cold miss fills", 32'(rd_beats - r0), 4);
        chk(wr_beats == w0, "R7 no write-back of empty way", 32'(wr_beats - w0), 0);
        for (int k = 0; k < 4; k++)
            chk(rd_log[(r0 + k) % 16] == mk(0, 0, k), "R4 fill beat order",
                rd_log[(r0 + k) % 16], mk(0, 0, k));

        // R2: other word of same line hits with no wait, no memory beat.
        r0 = rd_beats;
        access(1'b0, mk(0, 0, 1), '0, rd, cyc);
        chk(cyc == 0, "R2 hit latency", 32'(cyc), 0);
        chk(rd_beats == r0, "R2 hit no memory", 32'(rd_beats - r0), 0);
        chk(rd == ref_mem[mk(0,0,1) >> 2], "R3 hit word select", rd, ref_mem[mk(0,0,1) >> 2]);

        // R1: same tag in a different set is its own line.
        r0 = rd_beats;
        access(1'b0, mk(0, 1, 0), '0, rd, cyc);
        chk(rd_beats - r0 == 4, "R1 other set misses", 32'(rd_beats - r0), 4);
        access(1'b0, mk(0, 0, 3), '0, rd, cyc);
        chk(cyc == 0, "R1 set 0 line kept", 32'(cyc), 0);

        // R5: set 2, fill 4 ways, reuse tag 0, new tag 4 must evict tag 1.
        for (int t = 0; t < 4; t++) access(1'b0, mk(t, 2, 0), '0, rd, cyc);
        access(1'b0, mk(0, 2, 0), '0, rd, cyc);
        chk(cyc == 0, "R5 four ways resident", 32'(cyc), 0);
        access(1'b0, mk(4, 2, 0), '0, rd, cyc);
        access(1'b0, mk(0, 2, 1), '0, rd, cyc);
        chk(cyc == 0, "R5 recently used line kept", 32'(cyc), 0);
        access(1'b0, mk(3, 2, 1), '0, rd, cyc);
        chk(cyc == 0, "R5 younger line kept", 32'(cyc), 0);
        r0 = rd_beats;
        access(1'b0, mk(1, 2, 0), '0, rd, cyc);
        chk(rd_beats - r0 == 4, "R5 least recent line evicted", 32'(rd_beats - r0), 4);

        // R8: write miss in set 5 fills, writes cache only.
        r0 = rd_beats; w0 = wr_beats;
        access(1'b1, mk(0, 5, 1), 32'hDEAD_0001, rd, cyc);
        chk(rd_beats - r0 == 4, "R8 write miss fills", 32'(rd_beats - r0), 4);
        chk(mem_model[mk(0,5,1) >> 2] == init_val(mk(0,5,1) >> 2), "R8 memory untouched",
            mem_model[mk(0,5,1) >> 2], init_val(mk(0,5,1) >> 2));
        // R6: write hit, no memory traffic.
        w0 = wr_beats;
        access(1'b1, mk(0, 5, 2), 32'hBEEF_0002, rd, cyc);
        chk(cyc == 0 && wr_beats == w0, "R6 write hit cache only", 32'(wr_beats - w0), 0);
        rd_chk(mk(0, 5, 1), "R3 R8 merged word readback");
        rd_chk(mk(0, 5, 0), "R3 unwritten word of written line");
        // R7: evict dirty tag 0 line.
        for (int t = 1; t < 4; t++) access(1'b0, mk(t, 5, 0), '0, rd, cyc);
        w0 = wr_beats; r0 = rd_beats;
        access(1'b0, mk(4, 5, 3), '0, rd, cyc);
        chk(wr_beats - w0 == 4, "R7 dirty victim written", 32'(wr_beats - w0), 4);
        for (int k = 0; k < 4; k++)
            chk(wr_log[(w0 + k) % 16] == mk(0, 5, k), "R7 write-back beat address",
                wr_log[(w0 + k) % 16], mk(0, 5, k));
        chk(mem_model[mk(0,5,1) >> 2] == 32'hDEAD_0001, "R7 memory holds word 1",
            mem_model[mk(0,5,1) >> 2], 32'hDEAD_0001);
        chk(mem_model[mk(0,5,2) >> 2] == 32'hBEEF_0002, "R7 memory holds word 2",
            mem_model[mk(0,5,2) >> 2], 32'hBEEF_0002);
        chk(rd == ref_mem[mk(4,5,3) >> 2], "R3 data after write-back fill",
            rd, ref_mem[mk(4,5,3) >> 2]);
        // R7: clean victim (tag 1) causes no write.
        w0 = wr_beats;
        access(1'b0, mk(5, 5, 0), '0, rd, cyc);
        chk(wr_beats == w0, "R7 clean victim no write", 32'(wr_beats - w0), 0);

        // R3, R9: mixed sweep against a stalling memory.
        lfsr = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            int t, s, w;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            t = int'(lfsr[7:0]) % 6;
            s = int'(lfsr[10:8]);
            w = int'(lfsr[12:11]);
            if (lfsr[15])
                access(1'b1, mk(t, s, w), {lfsr, 16'(n)}, rd, cyc);
            else
                rd_chk(mk(t, s, w), "R3 R9 sweep read");
        end
        // R3: read back every word of the region.
        for (int t = 0; t < 6; t++)
            for (int s = 0; s < 8; s++)
                for (int w = 0; w < 4; w++)
                    rd_chk(mk(t, s, w), "R3 full readback");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule